// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes to it over a three-wire serial link: a serial clock, an active-low frame select and a data line. The block samples the three pins with its own system clock, detects serial clock falls and frame-select rises, and shifts data into a 16-bit word. When the frame select returns high, the word is decoded. A normal-operation word loads a new 12-bit converter code. A power-down word selects one of three output termination modes and leaves the code as it was.

While a frame is open, the block drives the last bit of its shift word on a serial output with an enable. Several devices can therefore share the clock and frame select and be chained data-out to data-in, each device seeing its own word after 16 clocks per device. Two reset paths return every register to zero scale in normal mode. One is a synchronous power-on reset. The other is an active-low clear that acts without waiting for a clock edge.

Top module: `serdac_front`

## Requirements
- R1: After the synchronous reset `rst`, `dac_code` is 0, `pd_mode` is 0 (normal), `sdo_oe` is 0, `sdo` is 0 and the shift word is all zeros.
- R2: The shift word moves by one bit only on a fall of `sclk` while `sync_n` is low. `sclk` activity while `sync_n` is high leaves the shift word untouched.
- R3: Bits enter MSB first. In the latched 16-bit word, bits 11..0 are the unsigned code, bits 13..12 are the mode field and bits 15..14 are ignored.
- R4: The rise of `sync_n` transfers the most recent 16 shifted bits. Frames longer than 16 clocks keep only the last 16.
- R5: Mode field 00 loads the code and sets `pd_mode` to 00. Mode 01 (1 kOhm to ground), 10 (100 kOhm) and 11 (open) only set `pd_mode`, and `dac_code` keeps its value.
- R6: `sdo_oe` is high exactly while a frame is open. `sdo` then shows the bit shifted in 16 clock falls earlier. When `sdo_oe` is low, `sdo` is 0.
- R7: Pulling `clr_n` low clears the code, the mode, the shift word and `sdo_oe` at once, with no clock edge needed. After release, the outputs change again only on a later rise of `sync_n`.
- R8: A frame with fewer than 16 clock falls latches the whole 16-bit shift word as it stands. The shift word keeps its contents between frames.
- R9: `dac_code` and `pd_mode` change only at a latch. During an open frame they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select; its rise latches the word |
| sdin | input | 1 | Serial data in, MSB first |
| dac_code | output | 12 | Converter code register |
| pd_mode | output | 2 | Output mode: 00 normal, 01 1 kOhm, 10 100 kOhm, 11 open |
| sdo | output | 1 | Serial data out for chaining |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The checker assumes that each serial pin level is held for more clock cycles than the synchronizer depth plus one, so every fall of `sclk` and every rise of `sync_n` is seen as exactly one strobe. It also assumes that `sdin` is steady around each clock fall and that a low pulse on `clr_n` covers at least one rising edge of `clk`. The stimulus changes pins only on the falling edge of `clk` and holds every level for four system clocks. It keeps `sclk` idling high, so frames open and close between clock falls. Clear pulses last several cycles, and `clr_n` is released only while the frame select is high.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    localparam int WORD_W   = 16;
    localparam int CODE_W   = 12;
    localparam int MODE_W   = 2;
    localparam int SPARE_W  = WORD_W - CODE_W - MODE_W;
    localparam int PIN_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        PD_NONE = 2'b00,
        PD_LOW  = 2'b01,
        PD_HIGH = 2'b10,
        PD_OPEN = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        pd_mode_e           mode;
        logic [CODE_W-1:0]  code;
    } frame_word_t;

    typedef struct packed {
        logic sclk;
        logic sync_n;
        logic sdin;
    } pins_t;

    typedef struct packed {
        logic shift;
        logic latch;
        logic frame;
        logic bit_in;
    } strobe_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, sync_n: 1'b1, sdin: 1'b0};

    function automatic frame_word_t shift_in(frame_word_t w, logic b);
        logic [WORD_W-1:0] v;
        v = w;
        return frame_word_t'({v[WORD_W-2:0], b});
    endfunction

    function automatic logic loads_code(pd_mode_e m);
        return m == PD_NONE;
    endfunction

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int              W      = 3,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            if (STAGES == 1) begin : g_single
                logic stage;
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n)   stage <= IDLE[b];
                    else if (rst) stage <= IDLE[b];
                    else          stage <= d[b];
                end
                assign q[b] = stage;
            end else begin : g_chain
                logic [STAGES-1:0] chain;
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n)   chain <= {STAGES{IDLE[b]}};
                    else if (rst) chain <= {STAGES{IDLE[b]}};
                    else          chain <= {chain[STAGES-2:0], d[b]};
                end
                assign q[b] = chain[STAGES-1];
            end
        end
    endgenerate

endmodule

// File: rtl/serdac_edge.sv
module serdac_edge
    import serdac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_n,
    input  pins_t   pins,
    output strobe_t strb
);

    logic sclk_q;
    logic sync_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sclk_q <= PINS_IDLE.sclk;
            sync_q <= PINS_IDLE.sync_n;
        end else if (rst) begin
            sclk_q <= PINS_IDLE.sclk;
            sync_q <= PINS_IDLE.sync_n;
        end else begin
            sclk_q <= pins.sclk;
            sync_q <= pins.sync_n;
        end
    end

    always_comb begin
        strb.shift  = sclk_q & ~pins.sclk & ~pins.sync_n;
        strb.latch  = ~sync_q & pins.sync_n;
        strb.frame  = ~pins.sync_n;
        strb.bit_in = pins.sdin;
    end

endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter
    import serdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_n,
    input  strobe_t     strb,
    output frame_word_t word,
    output logic        tail_bit
);

    frame_word_t word_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          word_q <= '0;
        else if (rst)        word_q <= '0;
        else if (strb.shift) word_q <= shift_in(word_q, strb.bit_in);
    end

    assign word     = word_q;
    assign tail_bit = word_q[WORD_W-1];

endmodule

// File: rtl/serdac_regs.sv
module serdac_regs
    import serdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              latch,
    input  frame_word_t       word,
    output logic [CODE_W-1:0] code,
    output pd_mode_e          mode
);

    logic [CODE_W-1:0] code_q;
    pd_mode_e          mode_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            code_q <= '0;
            mode_q <= PD_NONE;
        end else if (rst) begin
            code_q <= '0;
            mode_q <= PD_NONE;
        end else if (latch) begin
            mode_q <= word.mode;
            if (loads_code(word.mode)) code_q <= word.code;
        end
    end

    assign code = code_q;
    assign mode = mode_q;

endmodule

// File: rtl/serdac_front.sv
module serdac_front
    import serdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              sdo,
    output logic              sdo_oe
);

    logic [PIN_W-1:0] raw_pins;
    logic [PIN_W-1:0] sync_pins;
    pins_t            pins;
    strobe_t          strb;
    frame_word_t      held_word;
    logic             tail_bit;
    pd_mode_e         mode_q;
    logic             shift_en;
    logic             latch_en;

    assign raw_pins = {sclk, sync_n, sdin};

    serdac_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .d     (raw_pins),
        .q     (sync_pins)
    );

    assign pins = pins_t'(sync_pins);

    serdac_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .pins  (pins),
        .strb  (strb)
    );

    serdac_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .strb     (strb),
        .word     (held_word),
        .tail_bit (tail_bit)
    );

    serdac_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .latch (strb.latch),
        .word  (held_word),
        .code  (dac_code),
        .mode  (mode_q)
    );

    assign shift_en = strb.shift;
    assign latch_en = strb.latch;
    assign pd_mode  = mode_q;
    assign sdo_oe   = strb.frame;
    assign sdo      = strb.frame & tail_bit;

endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk
    import serdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic [CODE_W-1:0] dac_code,
    input logic [MODE_W-1:0] pd_mode,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              shift_en,
    input logic              latch_en,
    input logic [WORD_W-1:0] held_word
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> (dac_code == '0) && (pd_mode == '0) && !sdo_oe && (held_word == '0));

    // R7
    clear_async_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_code == '0) && (pd_mode == '0) && !sdo_oe && (held_word == '0));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !shift_en |=> $stable(held_word));

    // R5
    normal_load_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (latch_en && held_word[CODE_W+MODE_W-1:CODE_W] == 2'b00)
        |=> (dac_code == $past(held_word[CODE_W-1:0])) && (pd_mode == 2'b00));

    // R5
    pd_code_hold_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (latch_en && held_word[CODE_W+MODE_W-1:CODE_W] != 2'b00)
        |=> $stable(dac_code) && (pd_mode == $past(held_word[CODE_W+MODE_W-1:CODE_W])));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !latch_en |=> $stable(dac_code) && $stable(pd_mode));

    // R6
    sdo_idle_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !sdo_oe |-> !sdo);

endmodule

bind serdac_front serdac_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .shift_en  (shift_en),
    .latch_en  (latch_en),
    .held_word (held_word)
);

// File: tb/serdac_front_test.sv
module serdac_front_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SETTLE     = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        sdin = 1'b0;
    logic [11:0] dac_code;
    logic [1:0]  pd_mode;
    logic        sdo;
    logic        sdo_oe;

    int checks = 0;
    int fails  = 0;

    logic [15:0] model = '0;
    logic [11:0] exp_code = '0;
    logic [1:0]  exp_mode = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdac_front uut (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .sclk     (sclk),
        .sync_n   (sync_n),
        .sdin     (sdin),
        .dac_code (dac_code),
        .pd_mode  (pd_mode),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(dac_code == exp_code, req, "dac_code", {4'h0, dac_code}, {4'h0, exp_code});
        check(pd_mode == exp_mode, req, "pd_mode", {14'h0, pd_mode}, {14'h0, exp_mode});
        check(!sdo_oe && !sdo, req, "sdo idle", {14'h0, sdo_oe, sdo}, 16'h0);
    endtask

    // Sends the lowest n bits of bits, MSB first, then closes the frame.
    task automatic send(input logic [31:0] bits, input int n, input string req);
        sync_n = 1'b0;
        idle(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            idle(HALF);
            // R6: oe high in frame, sdo shows the bit from 16 falls earlier
            check(sdo_oe && (sdo == model[15]), "R6", "sdo in frame",
                  {14'h0, sdo_oe, sdo}, {14'h0, 1'b1, model[15]});
            sclk = 1'b0;
            model = {model[14:0], bits[i]};
            idle(HALF);
            sclk = 1'b1;
        end
        idle(HALF);
        // R9: nothing moves before the frame closes
        check(dac_code == exp_code && pd_mode == exp_mode, "R9", "held in frame",
              {2'b0, pd_mode, dac_code}, {2'b0, exp_mode, exp_code});
        sync_n = 1'b1;
        exp_mode = model[13:12];
        if (model[13:12] == 2'b00) exp_code = model[11:0];
        idle(SETTLE);
        check_outputs(req);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        idle(5);
        rst = 1'b0;
        idle(2);
        // R1: reset state
        check_outputs("R1");

        // R3 / R5: sweep all modes, several codes, spare bits varied
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 8; k++) begin
                logic [15:0] w;
                w = {k[1:0], m[1:0], 12'((k * 587 + m * 91 + 1) & 12'hfff)};
                send({16'h0, w}, 16, (m == 0) ? "R3" : "R5");
            end
        end

        // R3: walking one across the code field
        for (int b = 0; b < 12; b++) begin
            send({16'h0, 4'h0, 12'(1 << b)}, 16, "R3");
        end

        // R5: power-down word keeps the code
        send({16'h0, 16'h0ABC}, 16, "R5");
        send({16'h0, 16'h2FFF}, 16, "R5");
        check(dac_code == 12'hABC, "R5", "code kept in power-down",
              {4'h0, dac_code}, 16'h0ABC);

        // R4 / R6: 32-bit chained frame, last 16 bits win
        send({16'h1555, 16'h0321}, 32, "R4");
        send({16'h0FFF, 16'h3000, 16'h0000} >> 16, 32, "R4");

        // R2: sclk activity with frame select high is ignored
        send({16'h0, 16'h3000}, 16, "R2");
        sdin = 1'b1;
        for (int t = 0; t < 5; t++) begin
            sclk = 1'b0;
            idle(HALF);
            sclk = 1'b1;
            idle(HALF);
        end
        sdin = 1'b0;
        send(32'h0, 0, "R2");
        check(pd_mode == 2'b11, "R2", "shift word untouched", {14'h0, pd_mode}, 16'h3);

        // R8: short frames latch the whole held word
        send({16'h0, 16'h0123}, 16, "R8");
        send(32'h5, 4, "R8");
        check(pd_mode == 2'b01 && dac_code == 12'h123, "R8", "4-bit frame",
              {2'b0, pd_mode, dac_code}, 16'h1123);
        send(32'h0, 8, "R8");
        send(32'h0, 4, "R8");

        // R7: asynchronous clear, idle and mid-frame
        send({16'h0, 16'h0ABC}, 16, "R7");
        clr_n = 1'b0;
        #1;
        check(dac_code == 12'h0 && pd_mode == 2'b0, "R7", "async clear idle",
              {2'b0, pd_mode, dac_code}, 16'h0);
        idle(3);
        clr_n = 1'b1;
        model = '0; exp_code = '0; exp_mode = '0;
        idle(SETTLE);
        check_outputs("R7");
        send({16'h0, 16'h0456}, 16, "R7");
        sync_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < 4; i++) begin
            sdin = 1'b1; idle(HALF);
            sclk = 1'b0; idle(HALF);
            sclk = 1'b1;
        end
        sdin = 1'b0;
        clr_n = 1'b0;
        #1;
        check(!sdo_oe && dac_code == 12'h0, "R7", "async clear in frame",
              {3'b0, sdo_oe, dac_code}, 16'h0);
        idle(2);
        sync_n = 1'b1;
        idle(3);
        clr_n = 1'b1;
        model = '0; exp_code = '0; exp_mode = '0;
        idle(SETTLE);
        check_outputs("R7");
        // R8: shift word was cleared, so a 4-bit frame yields code 001
        send(32'h1, 4, "R8");
        check(dac_code == 12'h001, "R8", "cleared shift word",
              {4'h0, dac_code}, 16'h0001);

        // R1: synchronous reset after activity
        send({16'h0, 16'h1777}, 16, "R1");
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        model = '0; exp_code = '0; exp_mode = '0;
        idle(2);
        check_outputs("R1");
        send(32'h0, 0, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule